// File: doc/BRIEF.md
# Wakeup Interrupt Monitor

This always-on block watches a parameterised set of wake-capable input pins while the main processor is powered down. Each pin is brought into the clock domain through a two-stage synchroniser. Depending on its per-pin configuration, the block then looks for a rising edge, a falling edge, both edges, or a steady high or low level. A qualifying event sets a sticky status bit. Any status bit whose pin is also enabled drives a registered wake request towards the processor.

Software programs the block through a simple word-addressed 32-bit read/write port. Pins are packed 32 to a bank, and there are `ceil(NUM_PINS/32)` banks in each register group. The register space opens with two header words that read as zero. Five groups follow, each bank-interleaved: enable, falling-edge select, rising-edge select, polarity, and status. Before sleep, software writes zero to every status bank to clear pending events. A detection that lands in the same cycle as that clear still survives the clear.

Top module: `wake_monitor`

## Requirements
- R1: After reset every register word reads as zero and `wakeIrq` is low.
- R2: Word address `group*BANKS + bank + 2` selects the register of a group, with group codes enable = 0, falling = 1, rising = 2, polarity = 3, status = 4. Pin p sits in bank p/32 at bit p mod 32. The four configuration groups read back the last value written, and bits above the pin count read as zero.
- R3: Word addresses 0 and 1, and every address from `2 + 5*BANKS` upward, read as zero. Writes to those addresses change no register.
- R4: With its rising bit set, an enabled pin sets its status bit on a low-to-high input change. The bit is readable three clock edges after the change. A high-to-low change does not set it.
- R5: With its falling bit set, an enabled pin sets its status bit on a high-to-low change. A high input that does not change sets nothing.
- R6: With both edge bits set, either direction of change sets the status bit.
- R7: With both edge bits clear, the pin is level sensitive: polarity 1 means active high and polarity 0 means active low. For as long as the level holds, the status bit is set again every cycle.
- R8: A pin whose enable bit is clear never sets its status bit.
- R9: Status bits are sticky. A write to a status bank clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R10: A detection in the same cycle as a clearing status write leaves that status bit set.
- R11: `wakeIrq` equals the OR over all pins of (status AND enable), delayed by one register. It rises one edge after a qualifying status bit is set and falls one edge after the last such bit or its enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Asynchronous wake pins |
| busWe | input | 1 | Write strobe for the register port |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| wakeIrq | output | 1 | Registered wake request |

## Verification
Two functions can fall in the same cycle: a detection and a status-clearing write. The bench provokes this by changing a pin on a falling clock edge, then holding a zero write to that pin's status bank across the third rising edge that follows, which is the edge where the edge detector fires. A correct design must show the new bit set after that edge. A second bit, already latched before the write, must show as cleared, so the same readback proves both that the write took effect and that the detection won.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int GROUPS       = 5;
  localparam int HEADER_WORDS = 2;
  localparam int WORD_W       = 32;
  localparam int BANK_FIELD_W = 8;

  typedef enum logic [2:0] {
    GRP_ENABLE = 3'd0,
    GRP_FALL   = 3'd1,
    GRP_RISE   = 3'd2,
    GRP_POL    = 3'd3,
    GRP_STATUS = 3'd4
  } grp_e;

  typedef struct packed {
    logic [GROUPS-1:0]       wrGroup;
    logic [GROUPS-1:0]       rdGroup;
    logic [BANK_FIELD_W-1:0] bank;
  } strobe_t;
endpackage

// File: rtl/wm_ctrl.sv
module wm_ctrl
  import wm_pkg::*;
#(
  parameter int BANKS  = 2,
  parameter int ADDR_W = 8
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobes
);
  always_comb begin
    int addrI;
    int base;
    strobes = '0;
    addrI   = int'(busAddr);
    for (int g = 0; g < GROUPS; g++) begin
      base = HEADER_WORDS + g * BANKS;
      if (addrI >= base && addrI < base + BANKS) begin
        strobes.rdGroup[g] = 1'b1;
        strobes.wrGroup[g] = busWe;
        strobes.bank       = BANK_FIELD_W'(addrI - base);
      end
    end
  end
endmodule

// File: rtl/wm_datapath.sv
module wm_datapath
  import wm_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int BANKS    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  strobe_t             strobes,
  input  logic [WORD_W-1:0]   wrData,
  output logic [WORD_W-1:0]   rdData,
  output logic                wakeIrq,
  output logic [NUM_PINS-1:0] enableVec,
  output logic [NUM_PINS-1:0] statusVec
);
  localparam int PADDED = BANKS * WORD_W;

  logic [NUM_PINS-1:0] syncA, syncB, prevB;
  logic [NUM_PINS-1:0] fallVec, riseVec, polVec;
  logic [NUM_PINS-1:0] enableNext, fallNext, riseNext, polNext, statusNext;
  logic [NUM_PINS-1:0] selBank, hit;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int BKI = p / WORD_W;
    localparam int BTI = p % WORD_W;
    logic riseSeen, fallSeen, edgeMode, levelHit;

    assign selBank[p]  = (strobes.bank == BANK_FIELD_W'(BKI));
    assign riseSeen    = syncB[p] & ~prevB[p];
    assign fallSeen    = ~syncB[p] & prevB[p];
    assign edgeMode    = riseVec[p] | fallVec[p];
    assign levelHit    = polVec[p] ? syncB[p] : ~syncB[p];
    assign hit[p]      = enableVec[p] &
                         (edgeMode ? ((riseVec[p] & riseSeen) | (fallVec[p] & fallSeen))
                                   : levelHit);

    assign enableNext[p] = (strobes.wrGroup[GRP_ENABLE] && selBank[p]) ? wrData[BTI] : enableVec[p];
    assign fallNext[p]   = (strobes.wrGroup[GRP_FALL]   && selBank[p]) ? wrData[BTI] : fallVec[p];
    assign riseNext[p]   = (strobes.wrGroup[GRP_RISE]   && selBank[p]) ? wrData[BTI] : riseVec[p];
    assign polNext[p]    = (strobes.wrGroup[GRP_POL]    && selBank[p]) ? wrData[BTI] : polVec[p];
    assign statusNext[p] = ((strobes.wrGroup[GRP_STATUS] && selBank[p])
                              ? (statusVec[p] & wrData[BTI]) : statusVec[p]) | hit[p];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= '0;
      syncB     <= '0;
      prevB     <= '0;
      enableVec <= '0;
      fallVec   <= '0;
      riseVec   <= '0;
      polVec    <= '0;
      statusVec <= '0;
      wakeIrq   <= 1'b0;
    end else begin
      syncA     <= pinIn;
      syncB     <= syncA;
      prevB     <= syncB;
      enableVec <= enableNext;
      fallVec   <= fallNext;
      riseVec   <= riseNext;
      polVec    <= polNext;
      statusVec <= statusNext;
      wakeIrq   <= |(statusVec & enableVec);
    end
  end

  logic [GROUPS-1:0][PADDED-1:0] padded;
  always_comb begin
    padded = '0;
    padded[GRP_ENABLE][NUM_PINS-1:0] = enableVec;
    padded[GRP_FALL][NUM_PINS-1:0]   = fallVec;
    padded[GRP_RISE][NUM_PINS-1:0]   = riseVec;
    padded[GRP_POL][NUM_PINS-1:0]    = polVec;
    padded[GRP_STATUS][NUM_PINS-1:0] = statusVec;
  end

  always_comb begin
    int bankIdx;
    rdData  = '0;
    bankIdx = int'(strobes.bank);
    for (int g = 0; g < GROUPS; g++) begin
      if (strobes.rdGroup[g] && bankIdx < BANKS) begin
        rdData = padded[g][bankIdx*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/wake_monitor.sv
module wake_monitor
  import wm_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                wakeIrq
);
  localparam int BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;

  strobe_t             strobes;
  logic [NUM_PINS-1:0] enableVec;
  logic [NUM_PINS-1:0] statusVec;

  wm_ctrl #(.BANKS(BANKS), .ADDR_W(ADDR_W)) u_ctrl (
    .busWe   (busWe),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  wm_datapath #(.NUM_PINS(NUM_PINS), .BANKS(BANKS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .strobes   (strobes),
    .wrData    (busWdata),
    .rdData    (busRdata),
    .wakeIrq   (wakeIrq),
    .enableVec (enableVec),
    .statusVec (statusVec)
  );
endmodule

// File: rtl/wm_checker.sv
module wm_checker #(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWe,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [31:0]         busRdata,
  input logic                wakeIrq,
  input logic [NUM_PINS-1:0] enableVec,
  input logic [NUM_PINS-1:0] statusVec
);
  localparam int BANKS = (NUM_PINS + 31) / 32;
  localparam int LIMIT = 2 + 5 * BANKS;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (statusVec == '0 && enableVec == '0 && !wakeIrq));

  assert_header_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (int'(busAddr) < 2 || int'(busAddr) >= LIMIT) |-> (busRdata == 32'd0));

  assert_enable_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusVec & ~$past(statusVec) & ~$past(enableVec)) == '0));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> (($past(statusVec) & ~statusVec) == '0));

  assert_wake_rise_R11: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusVec & enableVec)) |=> wakeIrq);

  assert_wake_fall_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusVec & enableVec)) |=> !wakeIrq);
endmodule

bind wake_monitor wm_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_wm_check (
  .clk       (clk),
  .rstN      (rstN),
  .busWe     (busWe),
  .busAddr   (busAddr),
  .busRdata  (busRdata),
  .wakeIrq   (wakeIrq),
  .enableVec (enableVec),
  .statusVec (statusVec)
);

// File: tb/tb_wake_monitor.sv
`timescale 1ns/1ps
module tb_wake_monitor;
  localparam int NP = 40;
  localparam int BK = (NP + 31) / 32;
  localparam int AW = 8;
  localparam int G_EN = 0, G_FALL = 1, G_RISE = 2, G_POL = 3, G_ST = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          busWe = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          wakeIrq;
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  wake_monitor #(.NUM_PINS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .pinIn(pins), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .wakeIrq(wakeIrq)
  );

  function automatic int regAddr(int g, int b);
    return g * BK + b + 2;
  endfunction

  function automatic logic [31:0] bankMask(int b);
    if (b == BK - 1 && (NP % 32) != 0) return (32'd1 << (NP % 32)) - 32'd1;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] pinWord(int p);
    return 32'd1 << (p % 32);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = AW'(a); busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    busAddr = AW'(a);
    #1 d = busRdata;
  endtask

  task automatic setPin(int p, logic v);
    @(negedge clk);
    pins[p] = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic expectStatus(string req, logic [NP-1:0] exp);
    logic [63:0] e;
    logic [31:0] d;
    e = 64'(exp);
    for (int b = 0; b < BK; b++) begin
      rd(regAddr(G_ST, b), d);
      chk(req, d, e[b*32 +: 32]);
    end
  endtask

  task automatic teardown(int p);
    wr(regAddr(G_EN, p / 32), 32'd0);
    wr(regAddr(G_RISE, p / 32), 32'd0);
    wr(regAddr(G_FALL, p / 32), 32'd0);
    wr(regAddr(G_POL, p / 32), 32'd0);
    wr(regAddr(G_ST, p / 32), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NP-1:0] oh;
    int sel [5];
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: every word reads zero after reset
    for (int a = 0; a < 2 + 5 * BK + 2; a++) begin
      rd(a, d);
      chk("R1 reset word", d, 32'd0);
    end
    chk("R1 wake low", 32'(wakeIrq), 32'd0);

    // R2: configuration readback with upper-bank masking (enable written last)
    for (int g = 3; g >= 0; g--) begin
      for (int b = 0; b < BK; b++) begin
        logic [31:0] pat;
        pat = 32'hA5C3_0F00 ^ (32'h1111_1111 * 32'(g)) ^ 32'(b) ^ 32'hFF00_0000;
        wr(regAddr(g, b), pat);
        rd(regAddr(g, b), d);
        chk("R2 readback", d, pat & bankMask(b));
      end
    end
    wr(regAddr(G_EN, BK - 1), 32'hFFFF_FFFF);
    rd(regAddr(G_EN, BK - 1), d);
    chk("R2 upper bits zero", d, bankMask(BK - 1));
    for (int g = 0; g < 5; g++)
      for (int b = 0; b < BK; b++) wr(regAddr(g, b), 32'd0);
    expectStatus("R2 cleared", '0);

    // R3: header and out-of-range words
    wr(regAddr(G_FALL, 0), 32'h0000_1357);
    sel = '{0, 1, 2 + 5 * BK, 2 + 5 * BK + 1, 255};
    foreach (sel[i]) begin
      wr(sel[i], 32'hFFFF_FFFF);
      rd(sel[i], d);
      chk("R3 unused word", d, 32'd0);
    end
    rd(regAddr(G_FALL, 0), d);
    chk("R3 no side effect", d, 32'h0000_1357);
    wr(regAddr(G_FALL, 0), 32'd0);

    // R4: rising-edge sweep across every pin
    for (int p = 0; p < NP; p++) begin
      oh = '0; oh[p] = 1'b1;
      wr(regAddr(G_RISE, p / 32), pinWord(p));
      wr(regAddr(G_EN, p / 32), pinWord(p));
      setPin(p, 1'b1); settle();
      expectStatus("R4 rise", oh);
      wr(regAddr(G_ST, p / 32), 32'd0);
      setPin(p, 1'b0); settle();
      expectStatus("R4 fall ignored", '0);
      teardown(p);
    end

    // R5: falling edge
    sel = '{0, 13, 31, 32, 39};
    foreach (sel[i]) begin
      int p;
      p = sel[i];
      oh = '0; oh[p] = 1'b1;
      setPin(p, 1'b1); settle();
      wr(regAddr(G_FALL, p / 32), pinWord(p));
      wr(regAddr(G_EN, p / 32), pinWord(p));
      settle();
      expectStatus("R5 steady high", '0);
      setPin(p, 1'b0); settle();
      expectStatus("R5 fall", oh);
      teardown(p);
    end

    // R6: both edges
    sel = '{5, 36, 0, 31, 39};
    for (int i = 0; i < 2; i++) begin
      int p;
      p = sel[i];
      oh = '0; oh[p] = 1'b1;
      wr(regAddr(G_RISE, p / 32), pinWord(p));
      wr(regAddr(G_FALL, p / 32), pinWord(p));
      wr(regAddr(G_EN, p / 32), pinWord(p));
      setPin(p, 1'b1); settle();
      expectStatus("R6 rise", oh);
      wr(regAddr(G_ST, p / 32), 32'd0);
      expectStatus("R6 cleared", '0);
      setPin(p, 1'b0); settle();
      expectStatus("R6 fall", oh);
      teardown(p);
    end

    // R7: level modes
    oh = '0; oh[7] = 1'b1;
    wr(regAddr(G_EN, 0), pinWord(7));
    settle();
    expectStatus("R7 level low", oh);
    wr(regAddr(G_ST, 0), 32'd0);
    expectStatus("R7 level persists", oh);
    setPin(7, 1'b1); settle();
    wr(regAddr(G_ST, 0), 32'd0);
    settle();
    expectStatus("R7 level low inactive", '0);
    wr(regAddr(G_POL, 0), pinWord(7));
    settle();
    expectStatus("R7 level high", oh);
    teardown(7);
    setPin(7, 1'b0);
    oh = '0; oh[33] = 1'b1;
    wr(regAddr(G_POL, 1), pinWord(33));
    wr(regAddr(G_EN, 1), pinWord(33));
    settle();
    expectStatus("R7 level high inactive", '0);
    setPin(33, 1'b1); settle();
    expectStatus("R7 level high active", oh);
    teardown(33);
    setPin(33, 1'b0); settle();
    wr(regAddr(G_ST, 1), 32'd0);

    // R8: disabled pin never latches
    wr(regAddr(G_RISE, 0), pinWord(20));
    setPin(20, 1'b1); settle();
    expectStatus("R8 disabled", '0);
    setPin(20, 1'b0);
    teardown(20);

    // R9: write of 1 keeps a bit, write of 0 clears it
    wr(regAddr(G_RISE, 0), pinWord(2) | pinWord(4));
    wr(regAddr(G_EN, 0), pinWord(2) | pinWord(4));
    setPin(2, 1'b1); setPin(4, 1'b1); settle();
    wr(regAddr(G_ST, 0), pinWord(4));
    oh = '0; oh[4] = 1'b1;
    expectStatus("R9 selective clear", oh);
    wr(regAddr(G_ST, 0), 32'd0);
    teardown(0);
    pins = '0;
    settle();

    // R10: detection coincides with clearing write
    wr(regAddr(G_RISE, 0), pinWord(3) | pinWord(9));
    wr(regAddr(G_EN, 0), pinWord(3) | pinWord(9));
    setPin(3, 1'b1); settle();
    @(negedge clk) pins[9] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    busWe = 1'b1; busAddr = AW'(regAddr(G_ST, 0)); busWdata = 32'd0;
    @(posedge clk);
    @(negedge clk) busWe = 1'b0;
    #1 chk("R10 detection wins", busRdata, pinWord(9));
    settle();
    chk("R11 wake with enabled status", 32'(wakeIrq), 32'd1);
    teardown(0);
    pins = '0;
    settle();
    chk("R11 wake low after clear", 32'(wakeIrq), 32'd0);

    // R11: exact wake timing
    wr(regAddr(G_RISE, 0), pinWord(11));
    wr(regAddr(G_EN, 0), pinWord(11));
    @(negedge clk) pins[11] = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R11 wake not yet", 32'(wakeIrq), 32'd0);
    @(posedge clk);
    #1 chk("R11 wake rises", 32'(wakeIrq), 32'd1);
    wr(regAddr(G_EN, 0), 32'd0);
    chk("R11 wake holds one edge", 32'(wakeIrq), 32'd1);
    @(posedge clk);
    #1 chk("R11 wake drops on disable", 32'(wakeIrq), 32'd0);
    wr(regAddr(G_EN, 0), pinWord(11));
    @(posedge clk);
    #1 chk("R11 wake back", 32'(wakeIrq), 32'd1);
    wr(regAddr(G_ST, 0), 32'd0);
    @(posedge clk);
    #1 chk("R11 wake drops on clear", 32'(wakeIrq), 32'd0);
    teardown(11);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule